// File: doc/BRIEF.md
# Ping-Pong Ethernet Frame Buffer Controller

This block sits between a 32-bit memory-mapped bus and a simple Ethernet MAC. It owns the frame memory for both directions. Software writes an outgoing frame into a transmit buffer, sets its byte count and hands it over through a status word. The block then streams the frame out one byte per handshake and returns the buffer. Incoming frames arrive as a byte stream. The block packs them into a free receive buffer and flags that buffer as full. The bus side clears the flag once the frame has been read. Each direction can be built with one buffer or with two alternating buffers, chosen separately at build time.

Buffer ownership is tracked with two transmit status bits. Hardware drops the busy bit when the frame has left. The active bit stays set until software clears it as an acknowledgement. A second command, busy together with program-address, loads a new 48-bit station address from the start of the buffer and sends nothing to the MAC. One interrupt line combines transmit-completion pulses and receive-full levels. A global enable gates it.

The bus uses word addresses: bit 10 selects the receive side, bit 9 selects the second buffer, and bits 8:0 pick the word in the buffer. Within a buffer, word 0x1FD holds the byte count, word 0x1FE (first transmit buffer only) holds the global enable in bit 31, and word 0x1FF holds the status.

Top module: `pingpong_framebuf`

## Requirements
- R1: After reset, every status word, the global enable, the station address, `irq`, `tx_valid` and `bus_rvalid` are zero.
- R2: A bus write to a buffer data word is returned by a read of that word. Read data and `bus_rvalid` appear one cycle after the read request.
- R3: Writing a transmit status word with bit 0 (busy) set and bit 1 clear sends the byte count from word 0x1FD of that buffer. Byte k is taken from word k/4, lane k%4, with lane 0 in bits 31:24. `tx_last` marks the final byte, and `tx_valid`, `tx_data` and `tx_last` stay unchanged while `tx_ready` is low.
- R4: When the send completes, busy reads 0 and bit 31 (active) keeps the value software wrote. Active changes only on a software write.
- R5: Writing the status with bits 0 and 1 both set loads the first six buffer bytes into `station_addr`, first byte in bits 47:40. No byte is offered to the MAC, and bits 0 and 1 then read 0.
- R6: When both transmit buffers are pending, the first buffer is sent first, and the second is sent straight after it.
- R7: An incoming frame is written into the first receive buffer whose status bit 0 (done) is clear, trying the first buffer before the second. Bytes are packed like R3, and done is set in the cycle after the byte flagged `rx_last`.
- R8: A frame that arrives while every receive buffer has done set is dropped, leaving buffer contents and status unchanged.
- R9: A bus write can clear receive done by writing 0 to bit 0, but writing 1 never sets it. Bit 3 of the receive status is its interrupt enable.
- R10: `irq` is high for one cycle after a transmit busy bit falls with that buffer's bit 3 set. It is also high while any receive buffer has done and bit 3 set. Both hold only while global enable bit 31 of word 0x1FE is set, and `irq` stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | MAC accepts the byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| station_addr | output | 48 | Loaded station address |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume software behaves in a few ways. It leaves a transmit buffer's data and byte count alone while that buffer is busy. It does not rewrite a status word in the cycle its busy bit falls. The MAC supplies at most one incoming byte per cycle and always ends a frame with `rx_last`. The stimulus keeps within these limits. Every status write is issued only after polling shows the buffer idle, or before the frame it concerns has started. Receive frames are sent as whole bursts separated by idle cycles.

// File: rtl/pfb_pkg.sv
// Shared types and helpers for the ping-pong frame buffer.
// Assumes 32-bit bus words holding four frame bytes, first byte in the top lane.
package pfb_pkg;

    localparam int STAT_BUSY   = 0;
    localparam int STAT_PROG   = 1;
    localparam int STAT_IE     = 3;
    localparam int STAT_ACTIVE = 31;

    typedef enum logic [1:0] {
        TXE_IDLE,
        TXE_SEND,
        TXE_LOAD0,
        TXE_LOAD1
    } txe_state_t;

    typedef struct packed {
        logic active;
        logic ie;
        logic prog;
        logic busy;
    } tx_stat_t;

    // Select one byte of a word; lane 0 is the most significant byte.
    function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
        case (lane)
            2'd0:    return w[31:24];
            2'd1:    return w[23:16];
            2'd2:    return w[15:8];
            default: return w[7:0];
        endcase
    endfunction

endpackage

// File: rtl/pfb_txslot.sv
// One transmit buffer: frame memory, byte count and status bits.
// Software may only set busy (and program-address with it) while idle;
// the engine's hw_clear is the only way busy and program-address fall.
module pfb_txslot
    import pfb_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_word,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] bus_rd_word,
    output logic [31:0]   bus_rd_data,
    input  logic [AW-1:0] eng_rd_word,
    output logic [31:0]   eng_rd_data,
    input  logic          hw_clear,
    output logic [15:0]   len,
    output tx_stat_t      stat
);
    localparam int            DEPTH     = 1 << AW;
    localparam logic [AW-1:0] LEN_WORD  = AW'(DEPTH - 3);
    localparam logic [AW-1:0] STAT_WORD = AW'(DEPTH - 1);

    logic [31:0] mem [DEPTH];

    // Store bus writes into the frame memory.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_word] <= wr_data;
        end
    end

    // Byte count and status bits with software set / hardware clear rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len  <= '0;
            stat <= '0;
        end else begin
            if (wr_en && wr_word == LEN_WORD) begin
                len <= wr_data[15:0];
            end
            if (hw_clear) begin
                stat.busy <= 1'b0;
                stat.prog <= 1'b0;
            end
            if (wr_en && wr_word == STAT_WORD) begin
                stat.ie     <= wr_data[STAT_IE];
                stat.active <= wr_data[STAT_ACTIVE];
                if (wr_data[STAT_BUSY] && !stat.busy) begin
                    stat.busy <= 1'b1;
                    stat.prog <= wr_data[STAT_PROG];
                end
            end
        end
    end

    // Bus read view: registers overlay the top words of the buffer.
    always_comb begin
        if (bus_rd_word == LEN_WORD) begin
            bus_rd_data = {16'd0, len};
        end else if (bus_rd_word == STAT_WORD) begin
            bus_rd_data = {stat.active, 27'd0, stat.ie, 1'b0, stat.prog, stat.busy};
        end else begin
            bus_rd_data = mem[bus_rd_word];
        end
    end

    // Engine read port returns raw memory.
    assign eng_rd_data = mem[eng_rd_word];

endmodule

// File: rtl/pfb_rxslot.sv
// One receive buffer: frame memory written byte by byte from the MAC side,
// plus done and interrupt-enable bits. Done is set only by hardware.
module pfb_rxslot #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_word,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] bus_rd_word,
    output logic [31:0]   bus_rd_data,
    input  logic          mac_we,
    input  logic [AW-1:0] mac_word,
    input  logic [1:0]    mac_lane,
    input  logic [7:0]    mac_byte,
    input  logic          set_done,
    output logic          done,
    output logic          ie
);
    localparam int            DEPTH     = 1 << AW;
    localparam logic [AW-1:0] STAT_WORD = AW'(DEPTH - 1);

    logic [31:0] mem [DEPTH];

    // Frame memory: MAC byte writes take priority over bus word writes.
    always_ff @(posedge clk) begin
        if (mac_we) begin
            case (mac_lane)
                2'd0:    mem[mac_word][31:24] <= mac_byte;
                2'd1:    mem[mac_word][23:16] <= mac_byte;
                2'd2:    mem[mac_word][15:8]  <= mac_byte;
                default: mem[mac_word][7:0]   <= mac_byte;
            endcase
        end else if (wr_en && wr_word != STAT_WORD) begin
            mem[wr_word] <= wr_data;
        end
    end

    // Done is set by hardware, cleared by software; enable is plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            ie   <= 1'b0;
        end else begin
            if (wr_en && wr_word == STAT_WORD) begin
                ie   <= wr_data[3];
                done <= done & wr_data[0];
            end
            if (set_done) begin
                done <= 1'b1;
            end
        end
    end

    // Bus read view with the status word overlaid.
    always_comb begin
        if (bus_rd_word == STAT_WORD) begin
            bus_rd_data = {28'd0, ie, 2'b00, done};
        end else begin
            bus_rd_data = mem[bus_rd_word];
        end
    end

endmodule

// File: rtl/pfb_txeng.sv
// Transmit engine: picks a pending buffer (first buffer preferred), streams
// its bytes under a valid/ready handshake, or loads the station address.
// Assumes the selected buffer's data and count are stable while it is busy.
module pfb_txeng
    import pfb_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         busy,
    input  logic [1:0]         prog,
    input  logic [1:0][15:0]   len,
    output logic               cur,
    output logic [AW-1:0]      rd_word,
    input  logic [31:0]        rd_data,
    output logic [1:0]         clr,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    input  logic               tx_ready,
    output logic [47:0]        station_addr
);
    txe_state_t  state;
    logic [15:0] idx;
    logic        any;
    logic        pick;
    logic        fin;

    // Output decode, memory address and completion strobe.
    always_comb begin
        any      = |busy;
        pick     = !busy[0];
        tx_valid = (state == TXE_SEND);
        tx_data  = tx_valid ? lane_byte(rd_data, idx[1:0]) : 8'd0;
        tx_last  = tx_valid && (idx == len[cur] - 16'd1);
        rd_word  = idx[AW+1:2];
        fin      = 1'b0;
        case (state)
            TXE_IDLE:  fin = any && !prog[pick] && (len[pick] == 16'd0);
            TXE_SEND:  fin = tx_ready && tx_last;
            TXE_LOAD0: fin = 1'b0;
            TXE_LOAD1: fin = 1'b1;
        endcase
        clr = 2'b00;
        clr[(state == TXE_IDLE) ? pick : cur] = fin;
    end

    // Sequencer for selection, streaming and address loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= TXE_IDLE;
            cur          <= 1'b0;
            idx          <= '0;
            station_addr <= '0;
        end else begin
            case (state)
                TXE_IDLE: begin
                    if (any) begin
                        cur <= pick;
                        idx <= '0;
                        if (prog[pick]) begin
                            state <= TXE_LOAD0;
                        end else if (len[pick] != 16'd0) begin
                            state <= TXE_SEND;
                        end
                    end
                end
                TXE_SEND: begin
                    if (tx_ready) begin
                        if (tx_last) begin
                            state <= TXE_IDLE;
                        end else begin
                            idx <= idx + 16'd1;
                        end
                    end
                end
                TXE_LOAD0: begin
                    station_addr[47:16] <= rd_data;
                    idx                 <= 16'd4;
                    state               <= TXE_LOAD1;
                end
                TXE_LOAD1: begin
                    station_addr[15:0] <= rd_data[31:16];
                    state              <= TXE_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pfb_rxeng.sv
// Receive engine: claims the first non-full buffer at the first byte of a
// frame, writes bytes in order, flags done on the last byte, and discards
// whole frames when no buffer is free. Assumes every frame ends with rx_last.
module pfb_rxeng #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic [1:0]    full,
    output logic          we,
    output logic          slot,
    output logic [AW-1:0] word,
    output logic [1:0]    lane,
    output logic [7:0]    wbyte,
    output logic [1:0]    set_done
);
    localparam int LIMIT = ((1 << AW) - 1) * 4;

    logic        recv;
    logic        drop;
    logic        cur;
    logic [15:0] idx;
    logic        ok;
    logic        pick;
    logic        start;
    logic        writing;
    logic [15:0] bidx;

    // Buffer choice and byte placement for the current input byte.
    always_comb begin
        ok       = !(full[0] && full[1]);
        pick     = full[0];
        start    = rx_valid && !recv && !drop;
        slot     = start ? pick : cur;
        bidx     = start ? 16'd0 : idx;
        writing  = rx_valid && (recv || (start && ok));
        we       = writing && ({16'd0, bidx} < 32'(LIMIT));
        word     = bidx[AW+1:2];
        lane     = bidx[1:0];
        wbyte    = rx_data;
        set_done = 2'b00;
        set_done[slot] = writing && rx_last;
    end

    // Frame tracking: receiving, dropping and byte position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recv <= 1'b0;
            drop <= 1'b0;
            cur  <= 1'b0;
            idx  <= '0;
        end else if (rx_valid) begin
            if (rx_last) begin
                recv <= 1'b0;
                drop <= 1'b0;
            end else if (start) begin
                recv <= ok;
                drop <= !ok;
                cur  <= pick;
                idx  <= 16'd1;
            end else begin
                idx <= idx + 16'd1;
            end
        end
    end

endmodule

// File: rtl/pingpong_framebuf.sv
// Top level: bus decode, transmit and receive buffers (one or two each),
// the two engines, read-data register and the combined interrupt.
// Assumes one bus access per cycle and word addressing.
module pingpong_framebuf
    import pfb_pkg::*;
#(
    parameter int BUF_AW  = 9,
    parameter bit TX_PONG = 1'b1,
    parameter bit RX_PONG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [BUF_AW+1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic [47:0]       station_addr,
    output logic              irq
);
    localparam int                TX_N     = TX_PONG ? 2 : 1;
    localparam int                RX_N     = RX_PONG ? 2 : 1;
    localparam logic [BUF_AW-1:0] GIE_WORD = BUF_AW'((1 << BUF_AW) - 2);
    localparam logic [1:0]        RX_HAVE  = RX_PONG ? 2'b11 : 2'b01;

    logic [BUF_AW-1:0] word_a;
    logic              pong;
    logic              is_rx;
    logic [1:0]        tx_wr;
    logic [1:0]        rx_wr;
    logic              gie_q;

    logic [31:0]       tx_bus_rd [2];
    logic [31:0]       tx_eng_rd [2];
    tx_stat_t          tx_stat   [2];
    logic [1:0][15:0]  tx_len;
    logic [1:0]        tx_busy;
    logic [1:0]        tx_prog;
    logic [1:0]        tx_ie;
    logic [1:0]        tx_active;
    logic [1:0]        tx_clr;
    logic [1:0]        tx_busy_q;
    logic              eng_cur;
    logic [BUF_AW-1:0] eng_word;

    logic [31:0]       rx_bus_rd [2];
    logic [1:0]        rx_done;
    logic [1:0]        rx_ie;
    logic [1:0]        rx_set;
    logic              rx_we;
    logic              rx_slot;
    logic [BUF_AW-1:0] rx_word;
    logic [1:0]        rx_lane;
    logic [7:0]        rx_byte;

    // Address split and per-buffer write strobes.
    always_comb begin
        word_a = bus_addr[BUF_AW-1:0];
        pong   = bus_addr[BUF_AW];
        is_rx  = bus_addr[BUF_AW+1];
        for (int i = 0; i < 2; i++) begin
            tx_wr[i] = bus_en && bus_we && !is_rx && (pong == 1'(i));
            rx_wr[i] = bus_en && bus_we &&  is_rx && (pong == 1'(i));
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_tx
        if (i < TX_N) begin : g_on
            pfb_txslot #(.AW(BUF_AW)) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_en       (tx_wr[i]),
                .wr_word     (word_a),
                .wr_data     (bus_wdata),
                .bus_rd_word (word_a),
                .bus_rd_data (tx_bus_rd[i]),
                .eng_rd_word (eng_word),
                .eng_rd_data (tx_eng_rd[i]),
                .hw_clear    (tx_clr[i]),
                .len         (tx_len[i]),
                .stat        (tx_stat[i])
            );
        end else begin : g_off
            assign tx_bus_rd[i] = '0;
            assign tx_eng_rd[i] = '0;
            assign tx_len[i]    = '0;
            assign tx_stat[i]   = '0;
        end
        assign tx_busy[i]   = tx_stat[i].busy;
        assign tx_prog[i]   = tx_stat[i].prog;
        assign tx_ie[i]     = tx_stat[i].ie;
        assign tx_active[i] = tx_stat[i].active;
    end

    for (genvar i = 0; i < 2; i++) begin : g_rx
        if (i < RX_N) begin : g_on
            pfb_rxslot #(.AW(BUF_AW)) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_en       (rx_wr[i]),
                .wr_word     (word_a),
                .wr_data     (bus_wdata),
                .bus_rd_word (word_a),
                .bus_rd_data (rx_bus_rd[i]),
                .mac_we      (rx_we && (rx_slot == 1'(i))),
                .mac_word    (rx_word),
                .mac_lane    (rx_lane),
                .mac_byte    (rx_byte),
                .set_done    (rx_set[i]),
                .done        (rx_done[i]),
                .ie          (rx_ie[i])
            );
        end else begin : g_off
            assign rx_bus_rd[i] = '0;
            assign rx_done[i]   = 1'b0;
            assign rx_ie[i]     = 1'b0;
        end
    end

    pfb_txeng #(.AW(BUF_AW)) u_txeng (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (tx_busy),
        .prog         (tx_prog),
        .len          (tx_len),
        .cur          (eng_cur),
        .rd_word      (eng_word),
        .rd_data      (tx_eng_rd[eng_cur]),
        .clr          (tx_clr),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_last      (tx_last),
        .tx_ready     (tx_ready),
        .station_addr (station_addr)
    );

    pfb_rxeng #(.AW(BUF_AW)) u_rxeng (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_last  (rx_last),
        .full     (rx_done | ~RX_HAVE),
        .we       (rx_we),
        .slot     (rx_slot),
        .word     (rx_word),
        .lane     (rx_lane),
        .wbyte    (rx_byte),
        .set_done (rx_set)
    );

    // Global interrupt enable lives in the first transmit buffer's window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
        end else if (tx_wr[0] && word_a == GIE_WORD) begin
            gie_q <= bus_wdata[31];
        end
    end

    // Registered read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_en && !bus_we;
            if (bus_en && !bus_we) begin
                if (is_rx) begin
                    bus_rdata <= rx_bus_rd[pong];
                end else if (!pong && word_a == GIE_WORD) begin
                    bus_rdata <= {gie_q, 31'd0};
                end else begin
                    bus_rdata <= tx_bus_rd[pong];
                end
            end
        end
    end

    // Interrupt: transmit busy-fall pulse or receive-full level, gated globally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_busy_q <= '0;
            irq       <= 1'b0;
        end else begin
            tx_busy_q <= tx_busy;
            irq       <= gie_q && ((|(tx_busy_q & ~tx_busy & tx_ie)) || (|(rx_done & rx_ie)));
        end
    end

endmodule

// File: rtl/pfb_chk.sv
// Checker for pingpong_framebuf: protocol and ordering properties across the
// engines, status bits and interrupt. Attached with bind below.
module pfb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        irq,
    input logic        gie,
    input logic [47:0] station_addr,
    input logic        rx_valid,
    input logic        rx_last,
    input logic        rx_done0,
    input logic        tx_busy0,
    input logic        tx_active0
);
    // R3
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R4
    active_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_busy0) && $past(tx_active0)) |-> tx_active0);

    // R5
    addr_load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(station_addr) |-> !$past(tx_valid));

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done0) |-> $past(rx_valid && rx_last));

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(gie));

endmodule

bind pingpong_framebuf pfb_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .irq          (irq),
    .gie          (gie_q),
    .station_addr (station_addr),
    .rx_valid     (rx_valid),
    .rx_last      (rx_last),
    .rx_done0     (rx_done[0]),
    .tx_busy0     (tx_busy[0]),
    .tx_active0   (tx_active[0])
);

// File: tb/pingpong_framebuf_test.sv
`timescale 1ns/1ps
module pingpong_framebuf_test;
    localparam logic [10:0] TXP = 11'h000, TXQ = 11'h200, RXP = 11'h400, RXQ = 11'h600;
    localparam logic [10:0] LENW = 11'h1FD, GIEW = 11'h1FE, STW = 11'h1FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [47:0] station_addr;
    logic        irq;

    int tests = 0, fails = 0, irq_cnt = 0, cyc = 0;
    bit stall = 1'b0;
    logic [8:0] exp_q [$];
    logic [8:0] mon_e;
    logic [31:0] v;

    always #4 clk = ~clk;

    pingpong_framebuf uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .station_addr(station_addr), .irq(irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // MAC-side ready pattern, changed away from the active edge.
    always @(negedge clk) begin
        cyc++;
        tx_ready <= stall ? (cyc % 3 != 0) : 1'b1;
    end

    // Monitor: pops expected bytes from the scoreboard and counts irq cycles.
    initial forever begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (irq) irq_cnt++;
            if (tx_valid && tx_ready) begin
                tests++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R3 unexpected byte actual=%0h expected=none", tx_data);
                end else begin
                    mon_e = exp_q.pop_front();
                    if ({tx_last, tx_data} !== mon_e) begin
                        fails++;
                        $display("FAIL R3 byte actual=%0h expected=%0h", {tx_last, tx_data}, mon_e);
                    end
                end
            end
        end
    end

    task automatic bus_write(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    // Driver: pushes the expected byte stream for one frame.
    task automatic push_frame(input logic [63:0] bytes, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back({(k == n - 1), bytes[63 - 8*k -: 8]});
    endtask

    task automatic rx_send(input logic [63:0] bytes, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = bytes[63 - 8*k -: 8]; rx_last = (k == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_idle(input logic [10:0] a);
        logic [31:0] s;
        s = 32'h1;
        for (int k = 0; k < 4000 && s[0]; k++) bus_read(a, s);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", irq, 0);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 rvalid", bus_rvalid, 0);
        check("R1 station", station_addr, 0);
        bus_read(TXP | STW, v); check("R1 tx status", v, 0);
        bus_read(RXP | STW, v); check("R1 rx status", v, 0);
        bus_read(TXP | GIEW, v); check("R1 gie", v, 0);

        // R2 buffer write / read back
        bus_write(TXP | 11'h0, 32'h11223344);
        bus_write(TXP | 11'h1, 32'h55667788);
        bus_write(TXQ | 11'h0, 32'hC1C2C3C4);
        bus_read(TXP | 11'h0, v); check("R2 ping w0", v, 32'h11223344);
        bus_read(TXP | 11'h1, v); check("R2 ping w1", v, 32'h55667788);
        bus_read(TXQ | 11'h0, v); check("R2 pong w0", v, 32'hC1C2C3C4);

        // R3 / R4 single send with MAC stalls
        stall = 1'b1;
        bus_write(TXP | LENW, 32'd5);
        push_frame(64'h1122334455000000, 5);
        bus_write(TXP | STW, 32'h80000001);
        wait_idle(TXP | STW);
        repeat (2) @(negedge clk);
        check("R3 all bytes sent", exp_q.size(), 0);
        bus_read(TXP | STW, v); check("R4 active kept", v, 32'h80000000);
        bus_write(TXP | STW, 32'h0);
        bus_read(TXP | STW, v); check("R4 ack", v, 0);

        // R6 / R10 both buffers pending, pong raises the interrupt
        bus_write(TXP | GIEW, 32'h80000000);
        bus_write(TXP | LENW, 32'd6);
        bus_write(TXQ | LENW, 32'd3);
        irq_cnt = 0;
        push_frame(64'h112233445566_0000, 6);
        push_frame(64'hC1C2C3_0000000000, 3);
        bus_write(TXP | STW, 32'h80000001);
        bus_write(TXQ | STW, 32'h80000009);
        wait_idle(TXP | STW);
        wait_idle(TXQ | STW);
        repeat (3) @(negedge clk);
        check("R6 order and count", exp_q.size(), 0);
        check("R10 tx pulse count", irq_cnt, 1);
        bus_write(TXP | STW, 32'h0);
        bus_write(TXQ | STW, 32'h0);
        stall = 1'b0;

        // R5 station address load
        bus_write(TXP | 11'h0, 32'h02AABBCC);
        bus_write(TXP | 11'h1, 32'hDDEE0000);
        bus_write(TXP | LENW, 32'd6);
        bus_write(TXP | STW, 32'h00000003);
        wait_idle(TXP | STW);
        check("R5 station", station_addr, 48'h02AABBCCDDEE);
        bus_read(TXP | STW, v); check("R5 status", v, 0);

        // R7 receive into ping then pong, R10 level
        bus_write(RXP | STW, 32'h8);
        rx_send(64'h0102030405000000, 5);
        repeat (2) @(negedge clk);
        check("R10 rx irq", irq, 1);
        bus_read(RXP | 11'h0, v); check("R7 ping w0", v, 32'h01020304);
        bus_read(RXP | 11'h1, v); check("R7 ping w1 lane0", v[31:24], 8'h05);
        bus_read(RXP | STW, v); check("R7 ping done", v, 32'h9);
        rx_send(64'h0A0B0C0000000000, 3);
        bus_read(RXQ | 11'h0, v); check("R7 pong w0", v[31:8], 24'h0A0B0C);
        bus_read(RXQ | STW, v); check("R7 pong done", v, 32'h1);

        // R8 drop when both full
        rx_send(64'hEEEEEEEE00000000, 4);
        bus_read(RXP | 11'h0, v); check("R8 ping untouched", v, 32'h01020304);
        bus_read(RXQ | 11'h0, v); check("R8 pong untouched", v[31:8], 24'h0A0B0C);
        bus_read(RXP | STW, v); check("R8 ping status", v, 32'h9);

        // R9 software clear / no software set
        bus_write(RXP | STW, 32'h8);
        repeat (2) @(negedge clk);
        check("R9 irq drops", irq, 0);
        bus_write(RXP | STW, 32'h9);
        bus_read(RXP | STW, v); check("R9 no sw set", v, 32'h8);

        // R10 global enable off blocks interrupt
        bus_write(TXP | GIEW, 32'h0);
        rx_send(64'h7700000000000000, 1);
        repeat (2) @(negedge clk);
        check("R10 gated", irq, 0);
        bus_read(RXP | STW, v); check("R10 done present", v, 32'h9);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule